// File: doc/BRIEF.md
# Envelope Min-Max Capture Unit

This unit sits after the sample digitiser of an acquisition path and reduces a fast stream of sample pairs to the extremes seen over a programmable envelope interval. Each accepted beat carries two unsigned 8-bit samples, `pair_lo` and `pair_hi`. Four independent slots each hold their own minimum and maximum register. The beat count within the interval picks the slot, taken modulo four.

An interval opens with a seeding phase of four beats. In that phase the incoming pairs are written into the slots without any comparison. The remaining beats of the interval are folded into the seeds: a stored maximum is replaced only by a larger sample and a stored minimum only by a smaller one. After the last beat of the interval the unit emits all four slot extremes with a one-cycle strobe. The next beat, which may arrive in the same cycle as the strobe, seeds the following interval.

When envelope mode is off, the unit acts as a pass-through. Seeding is held on, every beat is written into all slots, and every beat is strobed out.

Top module: `env_minmax_capture`

## Requirements
- R1: During and straight after a synchronous reset, `env_strobe` is low and both `env_min` and `env_max` are zero. The beat counter is cleared, so `seed_phase` is high.
- R2: In envelope mode, `seed_phase` is high while fewer than four beats of the current interval have been accepted, and low afterwards.
- R3: A beat accepted while `seed_phase` is high writes `pair_lo` into the minimum and `pair_hi` into the maximum of slot (beat count mod 4), with no comparison.
- R4: A later beat in the interval compares both samples, unsigned, with slot (beat count mod 4). The maximum changes only to a larger sample and the minimum only to a smaller one.
- R5: An interval ends on the beat where the beat count reaches the effective length minus one. The effective length is `interval_len`, with a floor of four. `env_strobe` is high for exactly the one cycle after that beat.
- R6: The strobe presents all four slots, including the effect of the final beat. Slot k occupies bits [8k+7:8k] of `env_min` and of `env_max`.
- R7: A beat accepted in the strobe cycle counts as beat 0 of the next interval and is seeded, so no sample is lost.
- R8: With `env_mode` low, `seed_phase` is high. Every accepted beat is written into all four slots and is strobed in the next cycle, and the beat counter is held at zero.
- R9: A cycle with `beat_valid` low changes no slot and no counter and raises no strobe. `env_min` and `env_max` hold their values between strobes.
- R10: An `interval_len` below four behaves as four, so the interval is seeding only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| env_mode | input | 1 | 1 = envelope intervals, 0 = pass-through |
| interval_len | input | 16 | Beats per envelope interval (floor 4) |
| beat_valid | input | 1 | The pair inputs carry an accepted beat |
| pair_lo | input | 8 | Sample routed to the minimum when seeded |
| pair_hi | input | 8 | Sample routed to the maximum when seeded |
| seed_phase | output | 1 | The next accepted beat is seeded, not compared |
| env_strobe | output | 1 | One-cycle pulse: extremes are valid |
| env_min | output | 32 | Four slot minima, slot k at [8k+7:8k] |
| env_max | output | 32 | Four slot maxima, slot k at [8k+7:8k] |

## Verification
The close of one interval and the seeding of the next fall in the same cycle whenever beats arrive back to back. The final compare beat and the strobe it produces also line up. The bench drives uninterrupted beat trains across interval boundaries, including the shortest legal interval, where every beat seeds and a strobe follows every fourth beat. The strobed values must reflect the final beat, and the beat taken during the strobe must show up as a seed in the next emission rather than being merged into the old one. Random gaps in `beat_valid` and toggles of `env_mode` move these collisions to varied positions.

// File: rtl/env_mm_pkg.sv
package env_mm_pkg;

    typedef enum logic [1:0] {
        PH_PASS = 2'd0,
        PH_SEED = 2'd1,
        PH_FOLD = 2'd2
    } phase_e;

    localparam int unsigned SEED_BEATS = 4;

    function automatic logic [7:0] max3(input logic [7:0] s, input logic [7:0] x,
                                        input logic [7:0] y);
        logic [7:0] m;
        m = (x > s) ? x : s;
        return (y > m) ? y : m;
    endfunction

    function automatic logic [7:0] min3(input logic [7:0] s, input logic [7:0] x,
                                        input logic [7:0] y);
        logic [7:0] m;
        m = (x < s) ? x : s;
        return (y < m) ? y : m;
    endfunction

endpackage

// File: rtl/env_seq.sv
module env_seq
    import env_mm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SLOTS = 4,
    localparam int SL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             env_mode,
    input  logic             beat_valid,
    input  logic [CNT_W-1:0] interval_len,
    output phase_e           phase,
    output logic [SL_W-1:0]  slot_idx,
    output logic             last_beat
);
    logic [CNT_W-1:0] beat_cnt;
    logic [CNT_W-1:0] end_idx;

    // effective length has a floor of SLOTS beats
    always_comb begin
        if (interval_len < CNT_W'(SLOTS)) end_idx = CNT_W'(SLOTS - 1);
        else                              end_idx = interval_len - 1'b1;
    end

    always_comb begin
        if (!env_mode)                          phase = PH_PASS;
        else if (beat_cnt < CNT_W'(SEED_BEATS)) phase = PH_SEED;
        else                                    phase = PH_FOLD;
    end

    assign slot_idx  = beat_cnt[SL_W-1:0];
    assign last_beat = env_mode && (beat_cnt >= end_idx);

    always_ff @(posedge clk) begin
        if (rst || !env_mode)  beat_cnt <= '0;
        else if (beat_valid)   beat_cnt <= last_beat ? '0 : beat_cnt + 1'b1;
    end
endmodule

// File: rtl/env_slot.sv
module env_slot
    import env_mm_pkg::*;
#(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             seed,
    input  logic [SMP_W-1:0] s_lo,
    input  logic [SMP_W-1:0] s_hi,
    output logic [SMP_W-1:0] nxt_min,
    output logic [SMP_W-1:0] nxt_max
);
    logic [SMP_W-1:0] cur_min, cur_max;

    always_comb begin
        nxt_min = cur_min;
        nxt_max = cur_max;
        if (wr) begin
            if (seed) begin
                nxt_min = s_lo;
                nxt_max = s_hi;
            end else begin
                nxt_min = min3(cur_min, s_lo, s_hi);
                nxt_max = max3(cur_max, s_lo, s_hi);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_min <= '0;
            cur_max <= '0;
        end else if (wr) begin
            cur_min <= nxt_min;
            cur_max <= nxt_max;
        end
    end
endmodule

// File: rtl/env_emit.sv
module env_emit #(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [VEC_W-1:0] min_vec,
    input  logic [VEC_W-1:0] max_vec,
    output logic             strobe,
    output logic [VEC_W-1:0] out_min,
    output logic [VEC_W-1:0] out_max
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe  <= 1'b0;
            out_min <= '0;
            out_max <= '0;
        end else begin
            strobe <= fire;
            if (fire) begin
                out_min <= min_vec;
                out_max <= max_vec;
            end
        end
    end
endmodule

// File: rtl/env_minmax_capture.sv
module env_minmax_capture
    import env_mm_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int SLOTS = 4,
    parameter int CNT_W = 16,
    localparam int SL_W  = $clog2(SLOTS),
    localparam int VEC_W = SMP_W * SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             env_mode,
    input  logic [CNT_W-1:0] interval_len,
    input  logic             beat_valid,
    input  logic [SMP_W-1:0] pair_lo,
    input  logic [SMP_W-1:0] pair_hi,
    output logic             seed_phase,
    output logic             env_strobe,
    output logic [VEC_W-1:0] env_min,
    output logic [VEC_W-1:0] env_max
);
    phase_e           phase;
    logic [SL_W-1:0]  slot_idx;
    logic             last_beat;
    logic [VEC_W-1:0] min_vec, max_vec;
    logic             fire;

    env_seq #(.CNT_W(CNT_W), .SLOTS(SLOTS)) u_seq (
        .clk(clk), .rst(rst), .env_mode(env_mode), .beat_valid(beat_valid),
        .interval_len(interval_len), .phase(phase), .slot_idx(slot_idx),
        .last_beat(last_beat)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic wr_k;
        assign wr_k = beat_valid && ((phase == PH_PASS) || (slot_idx == SL_W'(k)));
        env_slot #(.SMP_W(SMP_W)) u_slot (
            .clk(clk), .rst(rst), .wr(wr_k), .seed(phase != PH_FOLD),
            .s_lo(pair_lo), .s_hi(pair_hi),
            .nxt_min(min_vec[k*SMP_W +: SMP_W]),
            .nxt_max(max_vec[k*SMP_W +: SMP_W])
        );
    end

    assign fire       = beat_valid && ((phase == PH_PASS) || last_beat);
    assign seed_phase = (phase != PH_FOLD);

    env_emit #(.VEC_W(VEC_W)) u_emit (
        .clk(clk), .rst(rst), .fire(fire), .min_vec(min_vec), .max_vec(max_vec),
        .strobe(env_strobe), .out_min(env_min), .out_max(env_max)
    );
endmodule

// File: rtl/env_minmax_capture_chk.sv
module env_minmax_capture_chk #(
    parameter int VEC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             env_mode,
    input logic             beat_valid,
    input logic             seed_phase,
    input logic             env_strobe,
    input logic [VEC_W-1:0] env_min,
    input logic [VEC_W-1:0] env_max
);
    p_idle_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |=> !env_strobe);

    p_hold_outputs_r9: assert property (@(posedge clk) disable iff (rst)
        !env_strobe |-> ($stable(env_min) && $stable(env_max)));

    p_pass_seed_r8: assert property (@(posedge clk) disable iff (rst)
        !env_mode |-> seed_phase);

    p_pass_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (!env_mode && beat_valid) |=> env_strobe);

    p_reseed_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        env_strobe |-> seed_phase);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!env_strobe && env_min == '0 && env_max == '0));
endmodule

bind env_minmax_capture env_minmax_capture_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .env_mode(env_mode), .beat_valid(beat_valid),
    .seed_phase(seed_phase), .env_strobe(env_strobe),
    .env_min(env_min), .env_max(env_max)
);

// File: tb/env_minmax_capture_bench.sv
module env_minmax_capture_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        env_mode = 1'b1;
    logic [15:0] interval_len = 16'd8;
    logic        beat_valid = 1'b0;
    logic [7:0]  pair_lo = '0, pair_hi = '0;
    logic        seed_phase, env_strobe;
    logic [31:0] env_min, env_max;

    int n_chk = 0, n_bad = 0;

    // model state
    int         m_cnt = 0;
    logic [7:0] m_min [4];
    logic [7:0] m_max [4];
    logic [31:0] e_min = '0, e_max = '0;
    logic        e_stb = 1'b0;

    always #10 clk = ~clk;

    env_minmax_capture u_env_minmax_capture (
        .clk(clk), .rst(rst), .env_mode(env_mode), .interval_len(interval_len),
        .beat_valid(beat_valid), .pair_lo(pair_lo), .pair_hi(pair_hi),
        .seed_phase(seed_phase), .env_strobe(env_strobe),
        .env_min(env_min), .env_max(env_max)
    );

    function automatic logic [7:0] bmax(input logic [7:0] x, input logic [7:0] y);
        return (x > y) ? x : y;
    endfunction
    function automatic logic [7:0] bmin(input logic [7:0] x, input logic [7:0] y);
        return (x < y) ? x : y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: check seed flag, apply inputs, predict, check outputs
    task automatic step(input logic v, input logic [7:0] lo, input logic [7:0] hi,
                        input string req);
        int eff;
        @(negedge clk);
        check("R2/R8 seed_phase", {31'd0, seed_phase},
              {31'd0, (!env_mode || m_cnt < 4)});
        beat_valid = v; pair_lo = lo; pair_hi = hi;
        e_stb = 1'b0;
        eff = (interval_len < 16'd4) ? 4 : int'(interval_len);
        if (!env_mode) begin
            m_cnt = 0;
            if (v) begin
                for (int k = 0; k < 4; k++) begin m_min[k] = lo; m_max[k] = hi; end
                e_stb = 1'b1;
            end
        end else if (v) begin
            int s = m_cnt % 4;
            if (m_cnt < 4) begin
                m_min[s] = lo; m_max[s] = hi;                       // R3
            end else begin
                m_min[s] = bmin(m_min[s], bmin(lo, hi));            // R4
                m_max[s] = bmax(m_max[s], bmax(lo, hi));
            end
            if (m_cnt >= eff - 1) begin e_stb = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end
        if (e_stb)
            for (int k = 0; k < 4; k++) begin
                e_min[k*8 +: 8] = m_min[k];
                e_max[k*8 +: 8] = m_max[k];
            end
        @(posedge clk); #1;
        check({req, " strobe (R5/R9)"}, {31'd0, env_strobe}, {31'd0, e_stb});
        check({req, " min (R6)"}, env_min, e_min);
        check({req, " max (R6)"}, env_max, e_max);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 4; k++) begin m_min[k] = '0; m_max[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 strobe", {31'd0, env_strobe}, 32'd0);
        check("R1 min", env_min, 32'd0);
        check("R1 max", env_max, 32'd0);
        check("R1 seed", {31'd0, seed_phase}, 32'd1);

        // R2 R3 R4 R5 R6: interval of 8, seeds then folds
        interval_len = 16'd8;
        step(1, 8'h40, 8'h50, "seed0");
        step(1, 8'h10, 8'h20, "seed1");
        step(1, 8'h80, 8'h90, "seed2");
        step(1, 8'h30, 8'h31, "seed3");
        step(1, 8'h45, 8'h4f, "fold inside R4");
        step(0, 8'h00, 8'hff, "gap R9");
        step(1, 8'h05, 8'hf0, "fold both R4");
        step(1, 8'h85, 8'h88, "fold none R4");
        step(1, 8'h2f, 8'h32, "last fold R5");
        // R7: back-to-back into next interval, the strobe-cycle beat seeds
        step(1, 8'hff, 8'hff, "reseed R7");
        step(1, 8'h00, 8'h00, "seed R7");
        step(1, 8'h11, 8'h22, "seed R7");
        step(1, 8'h33, 8'h44, "seed R7");
        for (int i = 0; i < 4; i++) step(1, 8'h60, 8'h61, "fold R4");

        // R10: short length behaves as four
        interval_len = 16'd2;
        for (int i = 0; i < 12; i++) step(1, 8'(i * 17), 8'(i * 19), "short R10");

        // R8: pass-through
        env_mode = 1'b0;
        step(1, 8'h12, 8'h34, "pass R8");
        step(1, 8'hfe, 8'h01, "pass R8");
        step(0, 8'h77, 8'h77, "pass idle R9");
        env_mode = 1'b1;
        interval_len = 16'd5;
        for (int i = 0; i < 10; i++) step(1, 8'(i), 8'(200 - i), "after pass R7");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic v;
            if ($urandom_range(0, 40) == 0) env_mode = ~env_mode;
            if ($urandom_range(0, 60) == 0) interval_len = 16'($urandom_range(0, 12));
            v = ($urandom_range(0, 3) != 0);
            step(v, 8'($urandom), 8'($urandom), "random R4/R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule